// File: doc/BRIEF.md
# Five-Lane Integer Bundle Issue Unit

This block takes one wide instruction bundle per clock: five ALU slots and a branch slot that are issued together. Each ALU slot carries a 4-bit opcode and three 32-bit operands. The opcode is checked against what its physical lane can do, and the legal slots are executed on integer operands. All five results, the per-slot flags and the branch outcome retire together on the next clock edge.

The lanes are not all the same. Lanes 0 to 3 are simple lanes that add, multiply and multiply-add. Together they can also form one dot product, which is reported on lane 0. Lane 4 is the extended lane. It also divides and shifts, and it completes a full 32-bit multiply or multiply-add in one cycle. It never takes part in a dot product. A slot that asks its lane for something the lane cannot do produces zero and raises its illegal flag, and the other slots are not affected.

Opcode encoding: 0 no-op, 1 add (a+b), 2 multiply (a*b), 3 multiply-add (a*b+c), 4 dot-product head, 5 dot-product continuation, 6 unsigned divide (a/b), 7 shift left logical, 8 shift right logical, 9 shift right arithmetic. Codes 10 to 15 are reserved. Slot k uses bits [4k+3:4k] of the opcode vector and bits [32k+31:32k] of each operand and result vector.

Top module: `vliw_issue_unit`

## Requirements
- R1: `in_ready_o` is low while `rst_ni` is low and high from the first clock edge after reset ends. A bundle is accepted on an edge where `in_valid_i` and `in_ready_o` are both high. Its results appear with `out_valid_o` high right after the next edge.
- R2: In lanes 0 to 3, codes 1, 2 and 3 give a+b, a*b and a*b+c, each modulo 2^32.
- R3: Lane 4 gives the same add, multiply and multiply-add results in the same single cycle.
- R4: Code 6 in lane 4 gives the unsigned quotient a/b. When b is zero, the result is all ones and that slot's `div_err_o` bit is set. `div_err_o` bits 0 to 3 are never set.
- R5: Codes 7, 8 and 9 in lane 4 shift a by b[4:0] only: logical left, logical right, or arithmetic right.
- R6: Codes 6 to 9 in lanes 0 to 3 set that slot's illegal bit and give a zero result. The other slots are computed as usual.
- R7: With code 4 in lane 0 and code 5 in each of lanes 1 to 3, lane 0 gives the sum of a_k*b_k for k = 0 to 3 (modulo 2^32). Lanes 1 to 3 give zero, and no illegal bit is raised.
- R8: When the dot-product group is incomplete, every member is flagged illegal and gives zero. The group is lane 0 holding code 4 plus any of lanes 1 to 3 holding code 5. This also applies to code 4 outside lane 0, to code 5 in lane 0, and to code 4 or 5 in lane 4.
- R9: `br_taken_o` retires with the bundle. It is high when `br_en_i` was high and the branch operand was zero (`br_on_nz_i` low) or non-zero (`br_on_nz_i` high). It is low otherwise.
- R10: Code 0 gives zero without a flag. Codes 10 to 15 are illegal in every lane and give zero.
- R11: After an edge that accepts no bundle, `out_valid_o`, `illegal_o`, `div_err_o` and `br_taken_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Bundle present |
| in_ready_o | output | 1 | Unit can accept a bundle |
| op_i | input | 20 | Five 4-bit slot opcodes |
| src_a_i | input | 160 | Operand a, per slot |
| src_b_i | input | 160 | Operand b, per slot |
| src_c_i | input | 160 | Operand c (addend), per slot |
| br_en_i | input | 1 | Branch slot occupied |
| br_on_nz_i | input | 1 | Branch condition: 1 = non-zero, 0 = zero |
| br_src_i | input | 32 | Branch operand |
| out_valid_o | output | 1 | Retired bundle present |
| res_o | output | 160 | Per-slot results |
| illegal_o | output | 5 | Per-slot capability violation |
| div_err_o | output | 5 | Per-slot divide-by-zero |
| br_taken_o | output | 1 | Branch taken |

## Verification
Every result, flag and branch outcome is due exactly one rising edge after the edge that accepts its bundle, and `in_ready_o` rises one edge after reset is released. The bench changes the inputs on a falling edge and reads the outputs on the next falling edge. That reading point lies after the single capturing register and before anything else can move, and the expected values are computed while the inputs are still applied. Idle cycles are checked the same way, one edge after a cycle with no accepted bundle.

// File: rtl/vliw_pkg.sv
package vliw_pkg;
  localparam int unsigned NUM_LANES    = 5;
  localparam int unsigned SIMPLE_LANES = 4;
  localparam int unsigned OP_W         = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP  = 4'd0,
    OP_ADD  = 4'd1,
    OP_MUL  = 4'd2,
    OP_MAD  = 4'd3,
    OP_DOT  = 4'd4,
    OP_DOTC = 4'd5,
    OP_DIV  = 4'd6,
    OP_SHL  = 4'd7,
    OP_SHR  = 4'd8,
    OP_SRA  = 4'd9
  } op_e;
endpackage

// File: rtl/vliw_cap_check.sv
module vliw_cap_check
  import vliw_pkg::*;
(
  input  logic [NUM_LANES*OP_W-1:0] op_i,
  output logic [NUM_LANES-1:0]      illegal_o,
  output logic                      dot_ok_o
);
  logic [OP_W-1:0] op [NUM_LANES];

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_split
    assign op[l] = op_i[l*OP_W +: OP_W];
  end

  always_comb begin
    dot_ok_o = (op[0] == OP_DOT);
    for (int k = 1; k < SIMPLE_LANES; k++) dot_ok_o &= (op[k] == OP_DOTC);
  end

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    localparam bit IS_HEAD = (l == 0);
    logic legal;
    if (l < SIMPLE_LANES) begin : g_simple
      always_comb begin
        case (op[l])
          OP_NOP, OP_ADD, OP_MUL, OP_MAD: legal = 1'b1;
          OP_DOT:  legal = IS_HEAD && dot_ok_o;
          OP_DOTC: legal = !IS_HEAD && dot_ok_o;
          default: legal = 1'b0;
        endcase
      end
    end else begin : g_ext
      always_comb begin
        case (op[l])
          OP_NOP, OP_ADD, OP_MUL, OP_MAD,
          OP_DIV, OP_SHL, OP_SHR, OP_SRA: legal = 1'b1;
          default: legal = 1'b0;
        endcase
      end
    end
    assign illegal_o[l] = !legal;
  end
endmodule

// File: rtl/vliw_lane_alu.sv
module vliw_lane_alu
  import vliw_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter bit          EXT    = 1'b0
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] c_i,
  input  logic              kill_i,
  output logic [DATA_W-1:0] res_o,
  output logic              div_err_o
);
  logic [DATA_W-1:0] prod, base_res, ext_res;
  logic              ext_hit, ext_derr;

  assign prod = a_i * b_i;

  always_comb begin
    case (op_i)
      OP_ADD:  base_res = a_i + b_i;
      OP_MUL:  base_res = prod;
      OP_MAD:  base_res = prod + c_i;
      default: base_res = '0;
    endcase
  end

  if (EXT) begin : g_ext
    localparam int unsigned SH_W = $clog2(DATA_W);
    logic [SH_W-1:0] sh;
    assign sh = b_i[SH_W-1:0];
    always_comb begin
      ext_hit  = 1'b1;
      ext_derr = 1'b0;
      case (op_i)
        OP_DIV: begin
          if (b_i == '0) begin
            ext_res  = '1;
            ext_derr = 1'b1;
          end else begin
            ext_res = a_i / b_i;
          end
        end
        OP_SHL:  ext_res = a_i << sh;
        OP_SHR:  ext_res = a_i >> sh;
        OP_SRA:  ext_res = $unsigned($signed(a_i) >>> sh);
        default: begin
          ext_res = '0;
          ext_hit = 1'b0;
        end
      endcase
    end
  end else begin : g_base
    assign ext_res  = '0;
    assign ext_hit  = 1'b0;
    assign ext_derr = 1'b0;
  end

  assign res_o     = kill_i ? '0 : (ext_hit ? ext_res : base_res);
  assign div_err_o = !kill_i && ext_derr;
endmodule

// File: rtl/vliw_dot_unit.sv
module vliw_dot_unit
  import vliw_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [SIMPLE_LANES*DATA_W-1:0] a_i,
  input  logic [SIMPLE_LANES*DATA_W-1:0] b_i,
  output logic [DATA_W-1:0]              sum_o
);
  always_comb begin
    sum_o = '0;
    for (int k = 0; k < SIMPLE_LANES; k++)
      sum_o += a_i[k*DATA_W +: DATA_W] * b_i[k*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/vliw_issue_unit.sv
module vliw_issue_unit
  import vliw_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        in_valid_i,
  output logic                        in_ready_o,
  input  logic [NUM_LANES*OP_W-1:0]   op_i,
  input  logic [NUM_LANES*DATA_W-1:0] src_a_i,
  input  logic [NUM_LANES*DATA_W-1:0] src_b_i,
  input  logic [NUM_LANES*DATA_W-1:0] src_c_i,
  input  logic                        br_en_i,
  input  logic                        br_on_nz_i,
  input  logic [DATA_W-1:0]           br_src_i,
  output logic                        out_valid_o,
  output logic [NUM_LANES*DATA_W-1:0] res_o,
  output logic [NUM_LANES-1:0]        illegal_o,
  output logic [NUM_LANES-1:0]        div_err_o,
  output logic                        br_taken_o
);
  localparam int unsigned DOT_W = SIMPLE_LANES * DATA_W;

  logic                        accept, dot_ok, br_hit;
  logic [NUM_LANES-1:0]        illegal_d, derr_d;
  logic [NUM_LANES*DATA_W-1:0] res_d;
  logic [DATA_W-1:0]           dot_sum;
  logic                        ready_q;

  assign in_ready_o = ready_q;
  assign accept     = in_valid_i && ready_q;

  vliw_cap_check u_cap (
    .op_i      (op_i),
    .illegal_o (illegal_d),
    .dot_ok_o  (dot_ok)
  );

  vliw_dot_unit #(.DATA_W(DATA_W)) u_dot (
    .a_i   (src_a_i[DOT_W-1:0]),
    .b_i   (src_b_i[DOT_W-1:0]),
    .sum_o (dot_sum)
  );

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [DATA_W-1:0] lane_res;
    vliw_lane_alu #(.DATA_W(DATA_W), .EXT(l >= SIMPLE_LANES)) u_alu (
      .op_i      (op_i[l*OP_W +: OP_W]),
      .a_i       (src_a_i[l*DATA_W +: DATA_W]),
      .b_i       (src_b_i[l*DATA_W +: DATA_W]),
      .c_i       (src_c_i[l*DATA_W +: DATA_W]),
      .kill_i    (illegal_d[l]),
      .res_o     (lane_res),
      .div_err_o (derr_d[l])
    );
    if (l == 0) begin : g_head
      assign res_d[l*DATA_W +: DATA_W] = dot_ok ? dot_sum : lane_res;
    end else begin : g_tail
      assign res_d[l*DATA_W +: DATA_W] = lane_res;
    end
  end

  assign br_hit = br_en_i && (br_on_nz_i ? (br_src_i != '0) : (br_src_i == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q     <= 1'b0;
      out_valid_o <= 1'b0;
      res_o       <= '0;
      illegal_o   <= '0;
      div_err_o   <= '0;
      br_taken_o  <= 1'b0;
    end else begin
      ready_q     <= 1'b1;
      out_valid_o <= accept;
      if (accept) begin
        res_o      <= res_d;
        illegal_o  <= illegal_d;
        div_err_o  <= derr_d;
        br_taken_o <= br_hit;
      end else begin
        illegal_o  <= '0;
        div_err_o  <= '0;
        br_taken_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vliw_issue_chk.sv
module vliw_issue_chk
  import vliw_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        in_valid_i,
  input logic                        in_ready_o,
  input logic [NUM_LANES*OP_W-1:0]   op_i,
  input logic                        br_en_i,
  input logic                        out_valid_o,
  input logic [NUM_LANES*DATA_W-1:0] res_o,
  input logic [NUM_LANES-1:0]        illegal_o,
  input logic [NUM_LANES-1:0]        div_err_o,
  input logic                        br_taken_o
);
  localparam int unsigned EXT_L = NUM_LANES - 1;
  logic [OP_W-1:0] ext_op;
  assign ext_op = op_i[EXT_L*OP_W +: OP_W];

  // R1
  ready_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> in_ready_o);

  // R1
  accept_retire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o);

  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> (illegal_o == '0) && (div_err_o == '0) && !br_taken_o);

  // R4
  div_err_simple_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_err_o[SIMPLE_LANES-1:0] == '0);

  // R4
  div_err_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_err_o[EXT_L] |-> (res_o[EXT_L*DATA_W +: DATA_W] == '1) && !illegal_o[EXT_L]);

  // R8
  ext_no_dot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && (ext_op == OP_DOT || ext_op == OP_DOTC) |=> illegal_o[EXT_L]);

  // R9
  branch_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && !br_en_i |=> !br_taken_o);

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    // R6
    illegal_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o && illegal_o[g] |-> res_o[g*DATA_W +: DATA_W] == '0);
  end
endmodule

bind vliw_issue_unit vliw_issue_chk #(.DATA_W(DATA_W)) u_issue_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .op_i        (op_i),
  .br_en_i     (br_en_i),
  .out_valid_o (out_valid_o),
  .res_o       (res_o),
  .illegal_o   (illegal_o),
  .div_err_o   (div_err_o),
  .br_taken_o  (br_taken_o)
);

// File: tb/vliw_issue_unit_tb_top.sv
module vliw_issue_unit_tb_top;
  import vliw_pkg::*;
  localparam int DW = 32;
  localparam int L  = NUM_LANES;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [L*OP_W-1:0] op_v;
  logic [L*DW-1:0]   a_v, b_v, c_v, res_v;
  logic br_en = 1'b0, br_nz = 1'b0;
  logic [DW-1:0] br_src = '0;
  logic out_valid, br_taken;
  logic [L-1:0] illegal, div_err;

  logic [3:0]    ops [L];
  logic [DW-1:0] a [L], b [L], c [L];

  int n_checks = 0, n_errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  always_comb begin
    for (int k = 0; k < L; k++) begin
      op_v[k*OP_W +: OP_W] = ops[k];
      a_v[k*DW +: DW] = a[k];
      b_v[k*DW +: DW] = b[k];
      c_v[k*DW +: DW] = c[k];
    end
  end

  vliw_issue_unit #(.DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .op_i(op_v), .src_a_i(a_v), .src_b_i(b_v), .src_c_i(c_v),
    .br_en_i(br_en), .br_on_nz_i(br_nz), .br_src_i(br_src),
    .out_valid_o(out_valid), .res_o(res_v), .illegal_o(illegal),
    .div_err_o(div_err), .br_taken_o(br_taken)
  );

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit dot_full();
    bit ok = (ops[0] == 4'd4);
    for (int k = 1; k < 4; k++) ok &= (ops[k] == 4'd5);
    return ok;
  endfunction

  function automatic bit legal(input int k);
    logic [3:0] o = ops[k];
    if (o <= 4'd3) return 1;
    if (o == 4'd4) return (k == 0) && dot_full();
    if (o == 4'd5) return (k >= 1) && (k <= 3) && dot_full();
    if (o >= 4'd6 && o <= 4'd9) return k == 4;
    return 0;
  endfunction

  function automatic logic [DW-1:0] exp_res(input int k);
    logic [DW-1:0] s;
    if (!legal(k)) return '0;
    case (ops[k])
      4'd1: return a[k] + b[k];
      4'd2: return a[k] * b[k];
      4'd3: return a[k] * b[k] + c[k];
      4'd4: begin
        s = '0;
        for (int j = 0; j < 4; j++) s += a[j] * b[j];
        return s;
      end
      4'd6: return (b[k] == '0) ? '1 : a[k] / b[k];
      4'd7: return a[k] << b[k][4:0];
      4'd8: return a[k] >> b[k][4:0];
      4'd9: return $unsigned($signed(a[k]) >>> b[k][4:0]);
      default: return '0;
    endcase
  endfunction

  function automatic string tag(input int k);
    logic [3:0] o = ops[k];
    if (o == 4'd0 || o >= 4'd10) return "R10";
    if (o == 4'd4 || o == 4'd5) return legal(k) ? "R7" : "R8";
    if (!legal(k)) return "R6";
    if (o == 4'd6) return "R4";
    if (o >= 4'd7) return "R5";
    return (k == 4) ? "R3" : "R2";
  endfunction

  // drive at a falling edge, check at the next falling edge
  task automatic run_bundle(input bit valid);
    logic [DW-1:0] e_res [L];
    logic [L-1:0]  e_ill, e_derr;
    logic          e_br;
    string         t [L];
    in_valid = valid;
    for (int k = 0; k < L; k++) begin
      e_res[k]  = exp_res(k);
      e_ill[k]  = !legal(k);
      e_derr[k] = legal(k) && ops[k] == 4'd6 && b[k] == '0;
      t[k]      = tag(k);
    end
    e_br = br_en && (br_nz ? (br_src != '0) : (br_src == '0));
    @(negedge clk);
    if (valid) begin
      check("R1", "out_valid", 64'(out_valid), 64'd1);
      for (int k = 0; k < L; k++) begin
        check(t[k], $sformatf("lane%0d result op=%0d", k, ops[k]), 64'(res_v[k*DW +: DW]), 64'(e_res[k]));
        check(t[k], $sformatf("lane%0d illegal", k), 64'(illegal[k]), 64'(e_ill[k]));
      end
      check("R4", "div_err", 64'(div_err), 64'(e_derr));
      check("R9", "br_taken", 64'(br_taken), 64'(e_br));
    end else begin
      check("R11", "out_valid idle", 64'(out_valid), 64'd0);
      check("R11", "illegal idle", 64'(illegal), 64'd0);
      check("R11", "div_err idle", 64'(div_err), 64'd0);
      check("R11", "br_taken idle", 64'(br_taken), 64'd0);
    end
  endtask

  task automatic set_all(input logic [3:0] o);
    for (int k = 0; k < L; k++) begin
      ops[k] = o; a[k] = $urandom; b[k] = $urandom; c[k] = $urandom;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    set_all(4'd0);
    repeat (3) @(negedge clk);
    check("R1", "ready in reset", 64'(in_ready), 64'd0);
    check("R11", "out_valid in reset", 64'(out_valid), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1", "ready after reset", 64'(in_ready), 64'd1);

    // R2 simple lane arithmetic, wraparound
    set_all(4'd3); a[0] = 32'hFFFF_FFFF; b[0] = 32'd2; c[0] = 32'd5;
    ops[1] = 4'd1; ops[2] = 4'd2; ops[4] = 4'd0;
    run_bundle(1);
    // R3 extended lane multiply-add in one cycle
    set_all(4'd0); ops[4] = 4'd3; a[4] = 32'h1234_5678; b[4] = 32'h9ABC_DEF0; c[4] = 32'd7;
    run_bundle(1);
    // R7 full dot product
    set_all(4'd5); ops[0] = 4'd4; ops[4] = 4'd2;
    run_bundle(1);
    // R8 broken group: lane 2 not a continuation
    set_all(4'd5); ops[0] = 4'd4; ops[2] = 4'd1; ops[4] = 4'd0;
    run_bundle(1);
    // R8 continuations without head, dot in lane 4
    set_all(4'd5); ops[0] = 4'd1; ops[4] = 4'd4;
    run_bundle(1);
    // R4 divide by zero, R6 divide in simple lane
    set_all(4'd1); ops[4] = 4'd6; b[4] = '0; ops[1] = 4'd6;
    run_bundle(1);
    // R4 normal divide
    set_all(4'd0); ops[4] = 4'd6; a[4] = 32'd1000; b[4] = 32'd7;
    run_bundle(1);
    // R5 shift amount uses low 5 bits only
    set_all(4'd7); ops[4] = 4'd9; a[4] = 32'h8000_0010; b[4] = 32'd37;
    run_bundle(1);
    set_all(4'd0); ops[4] = 4'd8; a[4] = 32'h8000_0010; b[4] = 32'hFFFF_FFE4;
    run_bundle(1);
    // R10 reserved codes and no-ops
    set_all(4'd12); ops[3] = 4'd0; ops[4] = 4'd15;
    run_bundle(1);
    // R9 branch forms
    set_all(4'd1); br_en = 1; br_nz = 0; br_src = '0; run_bundle(1);
    br_nz = 1; run_bundle(1);
    br_src = 32'd9; run_bundle(1);
    br_en = 0; run_bundle(1);
    // R11 idle cycle with a bundle that would raise flags
    set_all(4'd13); ops[4] = 4'd6; b[4] = '0; br_en = 1; br_nz = 0; br_src = '0;
    run_bundle(0);

    for (int i = 0; i < 400; i++) begin
      for (int k = 0; k < L; k++) begin
        ops[k] = ($urandom % 4 == 0) ? 4'($urandom % 16) : 4'($urandom % 10);
        a[k] = ($urandom % 3 == 0) ? $urandom % 64 : $urandom;
        b[k] = ($urandom % 4 == 0) ? $urandom % 3 : $urandom;
        c[k] = $urandom;
      end
      if ($urandom % 6 == 0) begin
        ops[0] = 4'd4;
        for (int k = 1; k < 4; k++) ops[k] = 4'd5;
      end
      br_en = 1'($urandom); br_nz = 1'($urandom);
      br_src = ($urandom % 2 == 0) ? '0 : $urandom;
      run_bundle(($urandom % 8) != 0);
    end
    finish_run();
  end
endmodule